// File: doc/BRIEF.md
# Converter Serial Port Frame Controller

This block is the device-side end of the synchronous serial port of a data converter. It watches a serial clock, an active-low chip select and a serial data input. It runs all of them through one system clock, `clk`, and finds the edges by comparing each input with its value one cycle earlier. Every rising serial-clock edge takes one instruction bit from `di` and advances a bit counter. Every falling edge moves the next bit of the outgoing result word onto `dout`. The block holds an output-format register with three settings: word length, sign enable and bit order. That register fixes how many serial clocks make up one frame.

Chip select can be used in two ways. It can stay low across many frames: each frame then runs for exactly the current frame length, and the next frame follows at once. It can also be pulsed once per exchange: a rising chip select then ends the frame at any point, so an exchange that only carries an instruction may stop after eight clocks. The block presents the decoded instruction fields with a one-cycle valid pulse. It takes the conversion result as a parallel word and does no conversion itself.

Top module: `adc_serial_port`

## Requirements
- R1: The frame length is the data length plus one when the sign bit is enabled. The data length is selected by length code 0 = 8, 1 = 12, 2 or 3 = 16, so frames are 8, 9, 12, 13, 16 or 17 serial clocks long.
- R2: The outgoing word carries `res_data[L-1:0]`, where L is the data length. It is sent most significant bit first when the order flag is 0 and least significant bit first when it is 1. When sign is enabled, `res_sign` is sent as the first bit, before the data, in either order.
- R3: The format changes only at the end of a frame in which a convert instruction (op 0) or a format instruction (op 3) was fully captured. The new length, order and sign apply from the next frame onward. Calibrate (op 1) and status (op 2) instructions leave the format unchanged.
- R4: With chip select held low, a frame ends after exactly frame-length rising serial clocks. The first bit of the next word appears on the falling edge that follows, and the next eight rising edges capture a new instruction.
- R5: A rising chip select ends the frame early. If at least eight bits were captured, the instruction is reported and applied. A frame of fewer than eight bits produces no valid pulse and no format change.
- R6: The instruction bits are captured in the order DI0 to DI7. Their fields are: op = DI0 + 2·DI1, length code = DI2 + 2·DI3, order flag = DI4, sign enable = DI5, channel = DI6 + 2·DI7. `instr_op` and `instr_chan` are updated with a single-cycle `instr_valid` pulse once DI7 is captured.
- R7: A rising chip select clears the bit counter and the output shift register. After stray serial clocks, the next frame therefore starts aligned.
- R8: `dout` is 0 while chip select is high. The first bit of a word is driven as soon as chip select falls.
- R9: After reset the format is 12-bit data, most significant bit first, sign off. `dout` and `instr_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock, idles low |
| cs_n | input | 1 | Active-low chip select |
| di | input | 1 | Serial instruction input |
| res_data | input | LEN_C | Conversion result, loaded at the start of each word |
| res_sign | input | 1 | Sign of the conversion result |
| dout | output | 1 | Serial result output |
| instr_valid | output | 1 | One-cycle pulse when an instruction is complete |
| instr_op | output | 2 | Opcode of the captured instruction |
| instr_chan | output | 2 | Channel field of the captured instruction |

## Verification
Each input event takes effect at the first `clk` edge that sees the new level. A rising serial clock captures its bit at that edge, and on the eighth bit `instr_valid` is high for the cycle that follows. A falling serial clock or a falling chip select changes `dout` at that same edge, and a rising chip select forces `dout` to 0 there. The bench drives inputs on the falling `clk` edge and holds each serial level for one full cycle. It reads `dout` just before raising the serial clock for the next bit, so each sample falls two `clk` edges after the falling edge that produced it. Pulse fields are latched on the falling `clk` edge in the middle of the pulse, and format changes are judged only through the words of later frames.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

   localparam int INSTR_W = 8;

   typedef enum logic [1:0] {
      OP_CONVERT = 2'd0,
      OP_CALIB   = 2'd1,
      OP_STATUS  = 2'd2,
      OP_FORMAT  = 2'd3
   } op_e;

   typedef struct packed {
      logic       sign_en;
      logic       lsb_first;
      logic [1:0] len_code;
   } fmt_t;

   // fields of the captured instruction, bit 0 being the first bit received
   function automatic fmt_t instr_fmt(input logic [5:0] b);
      fmt_t f;
      f.len_code  = b[3:2];
      f.lsb_first = b[4];
      f.sign_en   = b[5];
      return f;
   endfunction

endpackage

// File: rtl/adc_sp_fmt.sv
module adc_sp_fmt
   import adc_sp_pkg::*;
#(
   parameter int LEN_A = 8,
   parameter int LEN_B = 12,
   parameter int LEN_C = 16,
   parameter int CW    = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap_stb,
   input  logic [5:0]    cap_bits,
   input  logic          frame_end,
   output logic          lsb_first,
   output logic          sign_en,
   output logic [CW-1:0] data_len,
   output logic [CW-1:0] frame_len
);

   localparam fmt_t FMT_RST = '{sign_en: 1'b0, lsb_first: 1'b0, len_code: 2'd1};

   fmt_t fmt_q, pend_fmt;
   logic pend_q;
   op_e  cap_op;
   logic upd;

   assign cap_op = op_e'(cap_bits[1:0]);
   assign upd    = cap_stb && (cap_op == OP_CONVERT || cap_op == OP_FORMAT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fmt_q    <= FMT_RST;
         pend_fmt <= FMT_RST;
         pend_q   <= 1'b0;
      end else if (frame_end) begin
         if (upd)         fmt_q <= instr_fmt(cap_bits);
         else if (pend_q) fmt_q <= pend_fmt;
         pend_q <= 1'b0;
      end else if (upd) begin
         pend_q   <= 1'b1;
         pend_fmt <= instr_fmt(cap_bits);
      end
   end

   always_comb begin
      case (fmt_q.len_code)
         2'd0:    data_len = CW'(LEN_A);
         2'd1:    data_len = CW'(LEN_B);
         default: data_len = CW'(LEN_C);
      endcase
   end

   assign frame_len = data_len + CW'(fmt_q.sign_en);
   assign lsb_first = fmt_q.lsb_first;
   assign sign_en   = fmt_q.sign_en;

   // the format may only move at a frame boundary
   assert_fmt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> $stable(fmt_q));

endmodule

// File: rtl/adc_sp_rx.sv
module adc_sp_rx
   import adc_sp_pkg::*;
#(
   parameter int CW = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_edge,
   input  logic               sclk_rise,
   input  logic               di,
   input  logic [CW-1:0]      frame_len,
   output logic [CW-1:0]      cnt,
   output logic               cap_stb,
   output logic [INSTR_W-1:0] cap_bits,
   output logic               wrap,
   output logic               instr_valid,
   output logic [1:0]         instr_op,
   output logic [1:0]         instr_chan
);

   localparam int            IW     = $clog2(INSTR_W);
   localparam logic [CW-1:0] LAST_I = CW'(INSTR_W - 1);

   logic [INSTR_W-2:0] ibits;

   assign cap_stb  = sclk_rise && (cnt == LAST_I);
   assign cap_bits = {di, ibits};
   assign wrap     = sclk_rise && (cnt == frame_len - CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt         <= '0;
         ibits       <= '0;
         instr_valid <= 1'b0;
         instr_op    <= '0;
         instr_chan  <= '0;
      end else begin
         instr_valid <= cap_stb;
         if (cap_stb) begin
            instr_op   <= cap_bits[1:0];
            instr_chan <= cap_bits[INSTR_W-1:INSTR_W-2];
         end
         if (cs_edge) begin
            cnt   <= '0;
            ibits <= '0;
         end else if (sclk_rise) begin
            if (cnt < LAST_I) ibits[cnt[IW-1:0]] <= di;
            cnt <= wrap ? '0 : cnt + CW'(1);
         end
      end
   end

   assert_cnt_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < frame_len);

   assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid |=> !instr_valid);

endmodule

// File: rtl/adc_sp_tx.sv
module adc_sp_tx #(
   parameter int DATA_W = 16,
   parameter int CW     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic              clear,
   input  logic              lsb_first,
   input  logic              sign_en,
   input  logic [CW-1:0]     data_len,
   input  logic [DATA_W-1:0] res_data,
   input  logic              res_sign,
   output logic              bit_o
);

   logic [DATA_W-1:0] masked, rev, seq;
   logic [DATA_W:0]   word, sh_q;

   assign masked = res_data & ({DATA_W{1'b1}} >> (CW'(DATA_W) - data_len));

   for (genvar g = 0; g < DATA_W; g++) begin : g_rev
      assign rev[DATA_W-1-g] = masked[g];
   end

   assign seq  = lsb_first ? rev : (masked << (CW'(DATA_W) - data_len));
   assign word = sign_en ? {res_sign, seq} : {seq, 1'b0};

   always_ff @(posedge clk) begin
      if (!rst_n)     sh_q <= '0;
      else if (clear) sh_q <= '0;
      else if (load)  sh_q <= word;
      else if (shift) sh_q <= {sh_q[DATA_W-1:0], 1'b0};
   end

   assign bit_o = sh_q[DATA_W];

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
   import adc_sp_pkg::*;
#(
   parameter int LEN_A = 8,
   parameter int LEN_B = 12,
   parameter int LEN_C = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sclk,
   input  logic             cs_n,
   input  logic             di,
   input  logic [LEN_C-1:0] res_data,
   input  logic             res_sign,
   output logic             dout,
   output logic             instr_valid,
   output logic [1:0]       instr_op,
   output logic [1:0]       instr_chan
);

   localparam int CW = $clog2(LEN_C + 2);

   if (LEN_A < INSTR_W) begin : g_chk_short
      $error("shortest word must hold a full instruction");
   end
   if (!(LEN_A < LEN_B && LEN_B < LEN_C)) begin : g_chk_order
      $error("word lengths must rise strictly");
   end

   logic sclk_q, cs_q, active, reload_pend;
   logic cs_fall, cs_rise, cs_edge, sclk_rise, sclk_fall;
   logic frame_end, wrap, cap_stb, tx_bit;
   logic [INSTR_W-1:0] cap_bits;
   logic [CW-1:0] cnt, data_len, frame_len;
   logic lsb_first, sign_en;

   assign cs_fall   = cs_q & ~cs_n;
   assign cs_rise   = ~cs_q & cs_n;
   assign cs_edge   = cs_fall | cs_rise;
   assign sclk_rise = active & ~cs_n & sclk & ~sclk_q;
   assign sclk_fall = active & ~cs_n & ~sclk & sclk_q;
   assign frame_end = wrap | cs_rise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_q      <= 1'b0;
         cs_q        <= 1'b1;
         active      <= 1'b0;
         reload_pend <= 1'b0;
      end else begin
         sclk_q <= sclk;
         cs_q   <= cs_n;
         if (cs_fall)      active <= 1'b1;
         else if (cs_rise) active <= 1'b0;
         if (cs_edge)        reload_pend <= 1'b0;
         else if (wrap)      reload_pend <= 1'b1;
         else if (sclk_fall) reload_pend <= 1'b0;
      end
   end

   adc_sp_rx #(.CW(CW)) u_rx (
      .clk(clk), .rst_n(rst_n), .cs_edge(cs_edge), .sclk_rise(sclk_rise),
      .di(di), .frame_len(frame_len), .cnt(cnt), .cap_stb(cap_stb),
      .cap_bits(cap_bits), .wrap(wrap), .instr_valid(instr_valid),
      .instr_op(instr_op), .instr_chan(instr_chan)
   );

   adc_sp_fmt #(.LEN_A(LEN_A), .LEN_B(LEN_B), .LEN_C(LEN_C), .CW(CW)) u_fmt (
      .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .cap_bits(cap_bits[5:0]),
      .frame_end(frame_end), .lsb_first(lsb_first), .sign_en(sign_en),
      .data_len(data_len), .frame_len(frame_len)
   );

   adc_sp_tx #(.DATA_W(LEN_C), .CW(CW)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .load(cs_fall | (sclk_fall & reload_pend)),
      .shift(sclk_fall & ~reload_pend & (cnt != '0)),
      .clear(cs_rise), .lsb_first(lsb_first), .sign_en(sign_en),
      .data_len(data_len), .res_data(res_data), .res_sign(res_sign),
      .bit_o(tx_bit)
   );

   assign dout = active & tx_bit;

   assert_cs_rise_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise |=> (cnt == '0));

   assert_idle_dout_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise |=> !dout);

endmodule

// File: tb/adc_serial_port_test.sv
module adc_serial_port_test;
   timeunit 1ns; timeprecision 1ps;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, sclk, cs_n, di, res_sign;
   logic [15:0] res_data;
   logic dout, instr_valid;
   logic [1:0] instr_op, instr_chan;

   adc_serial_port uut (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .di(di),
      .res_data(res_data), .res_sign(res_sign), .dout(dout),
      .instr_valid(instr_valid), .instr_op(instr_op), .instr_chan(instr_chan)
   );

   int checks = 0, errors = 0, nvalid = 0;
   logic [1:0] last_op = 2'd0, last_chan = 2'd0;
   bit done = 1'b0;

   always @(negedge clk) begin
      if (rst_n && instr_valid) begin
         nvalid++;
         last_op   = instr_op;
         last_chan = instr_chan;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic int lenof(input int c);
      return (c == 0) ? 8 : (c == 1) ? 12 : 16;
   endfunction

   function automatic logic [7:0] mk(input int op, input int lc, input bit lsb,
                                     input bit sg, input int ch);
      logic [1:0] o2, l2, c2;
      o2 = 2'(op); l2 = 2'(lc); c2 = 2'(ch);
      return {c2, sg, lsb, l2, o2};
   endfunction

   // first bit of the frame sits at position 16
   function automatic logic [16:0] exp_word(input int lc, input bit lsb, input bit sg,
                                            input logic [15:0] r, input logic s);
      logic [16:0] w;
      int L, j;
      w = '0;
      L = lenof(lc);
      for (int p = 0; p < 17; p++) begin
         j = p - (sg ? 1 : 0);
         if (sg && p == 0) w[16-p] = s;
         else if (j < L)   w[16-p] = lsb ? r[j] : r[L-1-j];
      end
      return w;
   endfunction

   task automatic cs_low();
      @(negedge clk) cs_n = 1'b0;
      @(negedge clk);
   endtask

   task automatic cs_high();
      cs_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic send(input logic [7:0] ins, input int nb, output logic [16:0] got);
      got = '0;
      for (int k = 0; k < nb; k++) begin
         got[16-k] = dout;
         di   = (k < 8) ? ins[k] : 1'b0;
         sclk = 1'b1;
         @(negedge clk) sclk = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic frame_check(input string tag, input logic [16:0] got, input int lc,
                              input bit lsb, input bit sg, input int nb);
      logic [16:0] m, e;
      m = ~(17'h1ffff >> nb);
      e = exp_word(lc, lsb, sg, res_data, res_sign);
      chk(tag, 32'(got & m), 32'(e & m));
   endtask

   int cl, n0, tl, nl;
   bit cx, cs_, tx_, ts, nx, ns;
   logic [16:0] got;

   initial begin
      rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; di = 1'b0;
      res_data = '0; res_sign = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 reset dout", 32'(dout), 32'd0);
      chk("R9 reset valid", 32'(nvalid), 32'd0);
      cl = 1; cx = 1'b0; cs_ = 1'b0;

      for (int i = 0; i < 16; i++) begin
         tl  = i % 4; tx_ = i[2]; ts = i[3];
         res_data = 16'hA5C3 ^ 16'(i * 16'h1357);
         res_sign = ((i % 3) == 1);
         // format instruction, strobed, full frame in the old format
         n0 = nvalid;
         cs_low();
         send(mk(3, tl, tx_, ts, i % 4), lenof(cl) + cs_, got);
         cs_high();
         frame_check("R1 R2 R9 word before format load", got, cl, cx, cs_, lenof(cl) + cs_);
         chk("R6 one valid pulse", 32'(nvalid - n0), 32'd1);
         chk("R6 op field", 32'(last_op), 32'd3);
         chk("R6 chan field", 32'(last_chan), 32'(i % 4));
         chk("R8 dout low after cs rise", 32'(dout), 32'd0);
         cl = tl; cx = tx_; cs_ = ts;
         // calibrate, strobed after eight bits
         cs_low();
         send(mk(1, (tl + 1) % 4, !tx_, !ts, (i + 3) % 4), 8, got);
         cs_high();
         frame_check("R5 R2 eight-bit strobed word", got, cl, cx, cs_, 8);
         chk("R5 op after early end", 32'(last_op), 32'd1);
         // chip select held low for three frames
         nl = (i * 7 + 3) % 16;
         cs_low();
         send(mk(2, (tl + 2) % 4, tx_, !ts, (i + 1) % 4), lenof(cl) + cs_, got);
         frame_check("R3 R4 format kept after calibrate", got, cl, cx, cs_, lenof(cl) + cs_);
         nx = nl[2]; ns = nl[3];
         send(mk(0, nl % 4, nx, ns, (i + 2) % 4), lenof(cl) + cs_, got);
         frame_check("R3 R4 convert frame in old format", got, cl, cx, cs_, lenof(cl) + cs_);
         chk("R4 second frame op", 32'(last_op), 32'd0);
         chk("R4 second frame chan", 32'(last_chan), 32'((i + 2) % 4));
         cl = nl % 4; cx = nx; cs_ = ns;
         send(mk(2, 0, 1'b0, 1'b0, (i + 3) % 4), lenof(cl) + cs_, got);
         frame_check("R3 R1 new format next held frame", got, cl, cx, cs_, lenof(cl) + cs_);
         chk("R4 third frame chan", 32'(last_chan), 32'((i + 3) % 4));
         cs_high();
      end

      // frame cut below eight bits
      n0 = nvalid;
      cs_low();
      send(mk(3, (cl + 1) % 4, !cx, !cs_, 1), 5, got);
      cs_high();
      chk("R5 short frame no pulse", 32'(nvalid - n0), 32'd0);
      cs_low();
      send(mk(2, 0, 1'b0, 1'b0, 1), lenof(cl) + cs_, got);
      cs_high();
      frame_check("R5 short frame no format change", got, cl, cx, cs_, lenof(cl) + cs_);

      // stray clocks then realignment by chip select
      cs_low();
      send(8'hFF, 3, got);
      cs_high();
      cs_low();
      send(mk(2, 0, 1'b0, 1'b0, 2), lenof(cl) + cs_, got);
      cs_high();
      frame_check("R7 word after stray clocks", got, cl, cx, cs_, lenof(cl) + cs_);
      chk("R7 op after stray clocks", 32'(last_op), 32'd2);
      chk("R7 chan after stray clocks", 32'(last_chan), 32'd2);
      chk("R8 final idle dout", 32'(dout), 32'd0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog all requirements actual hung expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule